// File: doc/BRIEF.md
# Multi-Window Mailbox Message Sender

This block moves a message of arbitrary byte length across a group of `NWIN` adjacent 32-bit mailbox windows. The message arrives as a byte count on `start` and then as a ready/valid stream of 32-bit words. The engine cuts the message into rounds of at most `NWIN` words. It buffers each round and then sets the window status bits so that word 0 of the round lands in the highest-numbered window and is written last. That final write is the one event a receiver needs to watch.

The same module contains the matching receive drain. While enabled, it keeps every window except the last one masked. When the last window's status becomes non-zero, it snapshots all windows in reversed positions, wipes them in ascending order with an all-ones clear, and pulses a valid strobe. The window register array sits outside the block. It is reached through a set port (`wr_*`), a clear port (`clr_*`), the flattened status bus `rx_stat` and the status of the trigger window, `last_stat`.

Top module: `mbox_msg_tx`

## Requirements
- R1: A round holds at most NWIN*4 bytes. Word k of a round (k counted from 0 in stream order) is set into window index NWIN-1-k on `wr_idx`/`wr_data`.
- R2: Within a round the writes run from the highest word present down to word 0 on consecutive cycles. Window NWIN-1 is therefore the last window written, and nothing is written in the cycle after it.
- R3: In a round with fewer than NWIN words, the windows that have no word are not written.
- R4: When the byte count of a round is not a multiple of 4, the last word of that round keeps only its low (count mod 4) bytes, and its upper bytes are written as zero.
- R5: The first write of every round happens only after `last_stat` has been seen as zero. While it stays non-zero, no write is made.
- R6: If word 0 of a round, as received from the stream, is zero, `err` pulses for one cycle. No write of that round or of any later round is made, and the engine returns to idle.
- R7: The receive drain runs when enabled and when the last window is non-zero. It places window i into `rx_msg` slot NWIN-1-i (slot s is bits 32*s+31..32*s). It then clears windows 0..NWIN-1 in ascending order with all-ones `clr_data`, and pulses `rx_valid` one cycle after the last clear.
- R8: With `rx_en` high, `rx_mask` has every bit set except bit NWIN-1. With `rx_en` low, all bits are set and no drain starts.
- R9: `busy` is high from the cycle after an accepted `start` until completion. `done` pulses once when the last round's trigger write has been made. A `start` pulse while busy is ignored.
- R10: A `start` with a length of zero makes no write and pulses `done` in the next cycle.
- R11: After reset, `busy`, `done`, `err`, `wr_en`, `clr_en`, `rx_valid` and `in_ready` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a message (taken only when idle) |
| len_bytes | input | LW | Message length in bytes |
| in_word | input | 32 | Next message word |
| in_valid | input | 1 | `in_word` is valid |
| in_ready | output | 1 | Engine is loading words |
| busy | output | 1 | Message in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle abort pulse (zero word 0) |
| wr_en | output | 1 | Status-set write strobe |
| wr_idx | output | IW | Window index of the write |
| wr_data | output | 32 | Bits to set in that window |
| last_stat | input | 32 | Status of window NWIN-1 |
| rx_en | input | 1 | Receive drain enabled |
| rx_stat | input | NWIN*32 | Status of all windows, window i at bits 32*i+31..32*i |
| rx_mask | output | NWIN | Per-window interrupt mask, 1 = masked |
| clr_en | output | 1 | Status-clear strobe |
| clr_idx | output | IW | Window index being cleared |
| clr_data | output | 32 | Bits to clear (all ones) |
| rx_valid | output | 1 | One-cycle pulse, `rx_msg` complete |
| rx_msg | output | NWIN*32 | Reassembled round |

## Verification
The hand-off between the two halves is where timing is tightest. The drain's final clear of the trigger window and the sender's status poll for its next round can fall in the same cycle. The bench provokes this on every multi-round message by looping the sender's writes into a window model that feeds the drain. It also stalls the drain with `rx_en` low while a second message waits. The bench judges the outcome by timestamps: no write of the waiting round may appear before the drain's valid pulse. Each captured round must also equal the words computed from the byte count and stream, with reversal and tail masking applied.

// File: rtl/mbox_msg_tx.sv
module mbox_msg_tx #(
  parameter int NWIN = 4,
  parameter int LW = 16,
  localparam int IW = $clog2(NWIN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [LW-1:0]        len_bytes,
  input  logic [31:0]          in_word,
  input  logic                 in_valid,
  output logic                 in_ready,
  output logic                 busy,
  output logic                 done,
  output logic                 err,
  output logic                 wr_en,
  output logic [IW-1:0]        wr_idx,
  output logic [31:0]          wr_data,
  input  logic [31:0]          last_stat,
  input  logic                 rx_en,
  input  logic [NWIN*32-1:0]   rx_stat,
  output logic [NWIN-1:0]      rx_mask,
  output logic                 clr_en,
  output logic [IW-1:0]        clr_idx,
  output logic [31:0]          clr_data,
  output logic                 rx_valid,
  output logic [NWIN*32-1:0]   rx_msg
);
  localparam int WW = 32;
  localparam int RB = NWIN * 4;
  localparam logic [IW-1:0] TOP = IW'(NWIN - 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_CHECK, S_WAIT, S_WRITE} st_t;

  st_t            st;
  logic [LW-1:0]  rem;
  logic [IW-1:0]  k;
  logic [WW-1:0]  buff [NWIN];
  logic [LW-1:0]  rnd_b, rnd_w;
  logic [WW-1:0]  tmask;
  logic           rx_busy;
  logic [IW-1:0]  ci;

  assign rnd_b = (rem > LW'(RB)) ? LW'(RB) : rem;
  assign rnd_w = (rnd_b + LW'(3)) >> 2;

  always_comb begin
    case (rnd_b[1:0])
      2'd1:    tmask = 32'h0000_00FF;
      2'd2:    tmask = 32'h0000_FFFF;
      2'd3:    tmask = 32'h00FF_FFFF;
      default: tmask = '1;
    endcase
  end

  assign in_ready = (st == S_LOAD);
  assign busy     = (st != S_IDLE);
  assign wr_en    = (st == S_WRITE);
  assign wr_idx   = TOP - k;
  assign wr_data  = (LW'(k) == rnd_w - LW'(1)) ? (buff[k] & tmask) : buff[k];

  always_ff @(posedge clk) begin
    if (st == S_LOAD && in_valid) buff[k] <= in_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      rem  <= '0;
      k    <= '0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (len_bytes == '0) begin
            done <= 1'b1;
          end else begin
            rem <= len_bytes;
            k   <= '0;
            st  <= S_LOAD;
          end
        end
        S_LOAD: if (in_valid) begin
          if (LW'(k) == rnd_w - LW'(1)) st <= S_CHECK;
          else k <= k + IW'(1);
        end
        S_CHECK: begin
          if (buff[0] == '0) begin
            err <= 1'b1;
            st  <= S_IDLE;
          end else begin
            st <= S_WAIT;
          end
        end
        S_WAIT: if (last_stat == '0) begin
          k  <= IW'(rnd_w - LW'(1));
          st <= S_WRITE;
        end
        S_WRITE: begin
          if (k == '0) begin
            rem <= rem - rnd_b;
            if (rem == rnd_b) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              st <= S_LOAD;
            end
          end else begin
            k <= k - IW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rx_mask  = rx_en ? {1'b0, {(NWIN-1){1'b1}}} : '1;
  assign clr_en   = rx_busy;
  assign clr_idx  = ci;
  assign clr_data = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_busy  <= 1'b0;
      ci       <= '0;
      rx_valid <= 1'b0;
      rx_msg   <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (!rx_busy) begin
        if (rx_en && rx_stat[(NWIN-1)*WW +: WW] != '0) begin
          rx_busy <= 1'b1;
          ci      <= '0;
          for (int i = 0; i < NWIN; i++)
            rx_msg[(NWIN-1-i)*WW +: WW] <= rx_stat[i*WW +: WW];
        end
      end else if (ci == TOP) begin
        rx_busy  <= 1'b0;
        rx_valid <= 1'b1;
      end else begin
        ci <= ci + IW'(1);
      end
    end
  end

  AST_TRIGGER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_idx == TOP |=> !wr_en); // R2
  AST_WR_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_idx != TOP |=> wr_en && wr_idx == $past(wr_idx) + IW'(1)); // R2
  AST_ROUND_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !$past(wr_en) |-> $past(last_stat) == '0); // R5
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !wr_en && !busy); // R6
  AST_CLR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en && clr_idx != TOP |=> clr_en && clr_idx == $past(clr_idx) + IW'(1)); // R7
  AST_NO_DRAIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en && !clr_en |=> !clr_en); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !wr_en); // R9
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && len_bytes == '0 |=> done && !wr_en); // R10
endmodule

// File: tb/tb_mbox_msg_tx.sv
module tb_mbox_msg_tx;
  localparam int NWIN = 4;
  localparam int LW = 16;
  localparam int IW = 2;
  localparam int WW = 32;
  localparam int NV = 7;
  localparam logic [LW-1:0] VLEN [NV] = '{16'd16, 16'd40, 16'd6, 16'd23, 16'd1, 16'd32, 16'd12};
  localparam logic [31:0] VBASE [NV] = '{32'hA1B2C3D4, 32'h13572468, 32'h2468ACE1,
                                         32'h55AA33CC, 32'hCAFE0091, 32'h7E5D3C2B, 32'h44332211};
  localparam int VZERO [NV] = '{-1, -1, -1, -1, -1, 4, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic start, in_valid, in_ready, busy, done, err, wr_en, rx_en, clr_en, rx_valid;
  logic [LW-1:0] len_bytes;
  logic [31:0] in_word, wr_data, last_stat, clr_data;
  logic [IW-1:0] wr_idx, clr_idx;
  logic [NWIN*WW-1:0] rx_stat, rx_msg;
  logic [NWIN-1:0] rx_mask;
  logic [31:0] win [NWIN];

  mbox_msg_tx #(.NWIN(NWIN), .LW(LW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .len_bytes(len_bytes),
    .in_word(in_word), .in_valid(in_valid), .in_ready(in_ready),
    .busy(busy), .done(done), .err(err),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .last_stat(last_stat),
    .rx_en(rx_en), .rx_stat(rx_stat), .rx_mask(rx_mask),
    .clr_en(clr_en), .clr_idx(clr_idx), .clr_data(clr_data),
    .rx_valid(rx_valid), .rx_msg(rx_msg));

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) win[i] <= '0;
    end else begin
      if (wr_en) win[wr_idx] <= win[wr_idx] | wr_data;
      if (clr_en) win[clr_idx] <= win[clr_idx] & ~clr_data;
    end
  end
  always_comb for (int i = 0; i < NWIN; i++) rx_stat[i*WW +: WW] = win[i];
  assign last_stat = win[NWIN-1];

  int nchk = 0, nfail = 0;
  logic [31:0] stream [16];
  int snum = 0, sptr = 0, tcnt = 0;
  int nwlog, nrlog, ndone, nerr, nbusy;
  logic [IW-1:0] wl_idx [64];
  logic [31:0] wl_dat [64];
  int wl_t [64];
  logic [NWIN*WW-1:0] rl_msg [16];
  int rl_t [16];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    nwlog = 0; nrlog = 0; ndone = 0; nerr = 0; nbusy = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    start = 1'b0;
    tcnt++;
    if (wr_en && nwlog < 64) begin
      wl_idx[nwlog] = wr_idx; wl_dat[nwlog] = wr_data; wl_t[nwlog] = tcnt; nwlog++;
    end
    if (rx_valid && nrlog < 16) begin
      rl_msg[nrlog] = rx_msg; rl_t[nrlog] = tcnt; nrlog++;
    end
    if (done) ndone++;
    if (err) nerr++;
    if (busy) nbusy++;
    in_valid = (sptr < snum);
    in_word = in_valid ? stream[sptr] : '0;
    if (in_valid && in_ready) sptr++;
  endtask

  function automatic logic [31:0] vword(input int m, input int j);
    return (j == VZERO[m]) ? 32'h0 : (VBASE[m] ^ (32'h1111_1111 * 32'(j)));
  endfunction

  task automatic run_vec(input int m, input bit glitch);
    logic [IW-1:0] ew_idx [64];
    logic [31:0] ew_dat [64];
    string etag [64];
    logic [NWIN*WW-1:0] erx [16];
    logic [NWIN*WW-1:0] cur;
    logic [31:0] d, mk;
    int ne = 0, nr = 0, rem, rb, nw, t, r = 0, cyc = 0, post = 0;
    bit experr = 0;
    clear_logs();
    snum = (int'(VLEN[m]) + 3) / 4;
    for (int j = 0; j < snum; j++) stream[j] = vword(m, j);
    sptr = 0;
    tick();
    start = 1'b1; len_bytes = VLEN[m];
    while (cyc < 800 && post < 3*NWIN + 6) begin
      tick();
      cyc++;
      if (ndone + nerr > 0) post++;
      if (glitch && cyc == 6) begin start = 1'b1; len_bytes = 16'd4; end
    end
    rem = int'(VLEN[m]);
    while (rem > 0) begin
      rb = (rem > NWIN*4) ? NWIN*4 : rem;
      nw = (rb + 3) / 4;
      t = rb % 4;
      if (vword(m, r*NWIN) == 0) begin experr = 1; break; end
      cur = '0;
      for (int k = nw - 1; k >= 0; k--) begin
        d = vword(m, r*NWIN + k);
        etag[ne] = "R1";
        if (k == nw - 1 && t != 0) begin
          mk = (32'd1 << (8*t)) - 32'd1;
          d = d & mk;
          etag[ne] = "R4";
        end
        ew_idx[ne] = IW'(NWIN - 1 - k);
        ew_dat[ne] = d;
        cur[k*WW +: WW] = d;
        ne++;
      end
      erx[nr] = cur; nr++;
      rem -= rb; r++;
    end
    chk(ndone == (experr ? 0 : 1) && nerr == (experr ? 1 : 0), experr ? "R6 abort pulse" : "R9 done pulse",
        {ndone[15:0], nerr[15:0]}, {16'(experr ? 0 : 1), 16'(experr ? 1 : 0)});
    chk(nwlog == ne, experr ? "R6 write count" : "R3 write count", nwlog, ne);
    chk(nbusy > 0, "R9 busy seen", nbusy, 1);
    for (int i = 0; i < ne && i < nwlog; i++) begin
      chk(wl_idx[i] == ew_idx[i], "R2 window order", wl_idx[i], ew_idx[i]);
      chk(wl_dat[i] == ew_dat[i], etag[i], wl_dat[i], ew_dat[i]);
    end
    chk(nrlog == nr, "R7 round count", nrlog, nr);
    for (int i = 0; i < nr && i < nrlog; i++)
      chk(rl_msg[i] == erx[i], "R7 reassembled round", rl_msg[i], erx[i]);
    if (glitch) chk(nwlog == ne && ndone == 1, "R9 start while busy ignored", nwlog, ne);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    nchk++; nfail++;
    $display("FAIL R11 watchdog: actual hung, expected completion");
    finish_run();
  end

  initial begin
    int n;
    start = 1'b0; len_bytes = '0; in_valid = 1'b0; in_word = '0; rx_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err && !wr_en && !clr_en && !rx_valid && !in_ready, "R11 reset state",
        {busy, done, err, wr_en, clr_en, rx_valid, in_ready}, '0);
    chk(rx_mask == 4'b0111, "R8 mask enabled", rx_mask, 4'b0111);

    for (int m = 0; m < NV; m++) run_vec(m, m == 1);

    clear_logs(); snum = 0; sptr = 0;
    tick();
    start = 1'b1; len_bytes = '0;
    tick();
    chk(done && !busy, "R10 zero length done", {done, busy}, 2'b10);
    repeat (5) tick();
    chk(nwlog == 0 && ndone == 1, "R10 no writes", nwlog, 0);

    clear_logs();
    rx_en = 1'b0;
    stream[0] = 32'h0000_0055; stream[1] = 32'h0000_0066; snum = 1; sptr = 0;
    tick();
    start = 1'b1; len_bytes = 16'd4;
    n = 0;
    while (ndone == 0 && n < 100) begin tick(); n++; end
    repeat (20) tick();
    chk(rx_mask == 4'b1111, "R8 mask disabled", rx_mask, 4'b1111);
    chk(nrlog == 0 && nwlog == 1, "R8 no drain while disabled", nrlog, 0);
    snum = 2;
    start = 1'b1; len_bytes = 16'd4;
    repeat (20) tick();
    chk(nwlog == 1 && busy, "R5 stalled on busy window", {nwlog[7:0], busy}, {8'd1, 1'b1});
    rx_en = 1'b1;
    n = 0;
    while (ndone < 2 && n < 200) begin tick(); n++; end
    repeat (3*NWIN + 6) tick();
    chk(nrlog >= 1 && rl_msg[0][31:0] == 32'h55, "R7 stalled round drained", rl_msg[0][31:0], 32'h55);
    chk(nwlog == 2 && wl_dat[1] == 32'h66 && wl_idx[1] == 2'd3, "R5 resumed write",
        {wl_idx[1], wl_dat[1]}, {2'd3, 32'h66});
    chk(nrlog >= 1 && nwlog == 2 && rl_t[0] < wl_t[1], "R5 write after drain", wl_t[1], rl_t[0]);
    chk(nrlog == 2 && rl_msg[1][31:0] == 32'h66, "R7 second round drained", rl_msg[1][31:0], 32'h66);

    finish_run();
  end
endmodule